// File: doc/BRIEF.md
# Matrix-Vector Stream Wrapper

This block lets a fully parallel matrix-vector compute core be driven from a narrow 32-bit stream. A producer sends the N×N matrix in row-major order and then the N-element vector, one word per accepted beat on an AXI4-Stream slave port. The wrapper keeps every word in local registers. Only once the last one is in does it present the whole set to the core in parallel and pulse a start request. The core's arithmetic sits behind that handshake and is not part of this block.

When the core raises its done strobe, the wrapper captures the N result words at once. It then returns them in element order on an AXI4-Stream master port, marking the final element with TLAST, and honours back-pressure from the consumer. After the last result is accepted it is ready for the next matrix at once. N is one parameter, shared with the core.

The controller has four named states. LOAD accepts input words. ISSUE drives the start pulse for one cycle. COMPUTE waits for done. SEND drains the results. The transitions are:
- LOAD→ISSUE on the final input word.
- ISSUE→COMPUTE unconditionally.
- COMPUTE→SEND when done is seen.
- SEND→LOAD on the handshake of the last result.

Top module: `mv_stream_wrapper`

## Requirements
- R1: A synchronous active-low reset, applied at any point including mid-load, puts the block in LOAD with the word and result counters at zero: s_ready=1, m_valid=0, core_start=0. The next load then starts again from word 0.
- R2: In LOAD s_ready stays 1 for exactly N*N+N accepted words. It is 0 from the cycle after the final word until the block returns to LOAD. s_ready and m_valid are never 1 together.
- R3: Accepted word k, for k < N*N, lands on core_mat bits [k*32 +: 32], which is row k/N and column k%N. Word N*N+j lands on core_vec bits [j*32 +: 32].
- R4: core_start is 1 for exactly one cycle, the cycle right after the final input word is accepted (ISSUE). It is never 1 while s_ready is 1.
- R5: core_done is sampled only in COMPUTE, and the N words on core_res are captured on that cycle. A done strobe in any other state has no effect.
- R6: In SEND the captured elements appear on m_data in order 0..N-1. Element i comes from core_res bits [i*32 +: 32]. The index advances only on a cycle with m_valid=1 and m_ready=1.
- R7: While m_valid=1 and m_ready=0, m_valid, m_data and m_last hold their values into the next cycle.
- R8: m_last is 1 only while element N-1 is presented, and never with m_valid=0.
- R9: s_last has no effect on sequencing. Only the word count ends LOAD.
- R10: In the cycle after the handshake of element N-1, the block is back in LOAD: s_ready=1 and m_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_data | input | 32 | Input stream word |
| s_valid | input | 1 | Input stream valid |
| s_last | input | 1 | Input stream last marker (ignored) |
| s_ready | output | 1 | Input stream ready, high only in LOAD |
| m_data | output | 32 | Result stream word |
| m_valid | output | 1 | Result stream valid, high only in SEND |
| m_last | output | 1 | High with result element N-1 |
| m_ready | input | 1 | Result stream ready from consumer |
| core_mat | output | N*N*32 | Stored matrix, row-major, to the core |
| core_vec | output | N*32 | Stored vector to the core |
| core_start | output | 1 | One-cycle start request to the core |
| core_done | input | 1 | Core completion strobe |
| core_res | input | N*32 | Core result vector |

## Verification
The assertions check the following on every cycle:
- The two stream directions are never active together.
- The start request is a single-cycle pulse, and it never overlaps loading.
- Stalled output beats hold stable.
- The last marker appears only on valid beats.
- The block re-enters LOAD straight after the final result.

Only the bench's scenarios can show the rest, and they cover the main function across several frames:
- Word placement in row-major order.
- Capture of the result on the done cycle alone.
- Element ordering under irregular input gaps and output stalls.
- Indifference to spurious done strobes and stray s_last markers.
- Recovery from a reset in the middle of a load.

// File: rtl/mvw_pkg.sv
package mvw_pkg;
    typedef enum logic [1:0] {
        ST_LOAD    = 2'd0,
        ST_ISSUE   = 2'd1,
        ST_COMPUTE = 2'd2,
        ST_SEND    = 2'd3
    } mvw_state_e;
endpackage

// File: rtl/mvw_in_buf.sv
module mvw_in_buf #(
    parameter int N = 3,
    parameter int W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [W-1:0]     wr_data,
    output logic             load_done,
    output logic [N*N*W-1:0] mat_flat,
    output logic [N*W-1:0]   vec_flat
);
    localparam int TOTAL = N * N + N;
    localparam int CW    = $clog2(TOTAL);

    logic [CW-1:0] cnt_q;

    // Final word of the frame: the count alone ends loading.
    assign load_done = wr_en && (cnt_q == CW'(TOTAL - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_en) begin
            cnt_q <= load_done ? '0 : cnt_q + CW'(1);
        end
    end

    for (genvar k = 0; k < TOTAL; k++) begin : g_word
        logic [W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (wr_en && (cnt_q == CW'(k))) begin
                word_q <= wr_data;
            end
        end
        if (k < N * N) begin : g_mat
            assign mat_flat[k*W +: W] = word_q;
        end else begin : g_vec
            assign vec_flat[(k-N*N)*W +: W] = word_q;
        end
    end
endmodule

// File: rtl/mvw_out_seq.sv
module mvw_out_seq #(
    parameter int N = 3,
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cap,
    input  logic [N*W-1:0] cap_data,
    input  logic           adv,
    output logic [W-1:0]   out_data,
    output logic           out_last
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] idx_q;
    logic [W-1:0]  res_q [N];

    assign out_last = (idx_q == IW'(N - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (cap) begin
            idx_q <= '0;
        end else if (adv) begin
            idx_q <= out_last ? '0 : idx_q + IW'(1);
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_res
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                res_q[i] <= '0;
            end else if (cap) begin
                res_q[i] <= cap_data[i*W +: W];
            end
        end
    end

    always_comb begin
        out_data = '0;
        for (int i = 0; i < N; i++) begin
            if (idx_q == IW'(i)) begin
                out_data = res_q[i];
            end
        end
    end
endmodule

// File: rtl/mv_stream_wrapper.sv
module mv_stream_wrapper
    import mvw_pkg::*;
#(
    parameter int N = 3,
    parameter int W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     s_data,
    input  logic             s_valid,
    input  logic             s_last,
    output logic             s_ready,
    output logic [W-1:0]     m_data,
    output logic             m_valid,
    output logic             m_last,
    input  logic             m_ready,
    output logic [N*N*W-1:0] core_mat,
    output logic [N*W-1:0]   core_vec,
    output logic             core_start,
    input  logic             core_done,
    input  logic [N*W-1:0]   core_res
);
    mvw_state_e state_q, state_d;

    logic load_done;
    logic seq_last;
    logic wr_en;
    logic cap;
    logic adv;
    logic unused_s_last;

    // The input marker plays no part in sequencing.
    assign unused_s_last = s_last;

    assign wr_en = s_valid && s_ready;
    assign cap   = (state_q == ST_COMPUTE) && core_done;
    assign adv   = m_valid && m_ready;

    mvw_in_buf #(.N(N), .W(W)) u_in_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (s_data),
        .load_done (load_done),
        .mat_flat  (core_mat),
        .vec_flat  (core_vec)
    );

    mvw_out_seq #(.N(N), .W(W)) u_out_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (cap),
        .cap_data (core_res),
        .adv      (adv),
        .out_data (m_data),
        .out_last (seq_last)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD:    if (load_done)          state_d = ST_ISSUE;
            ST_ISSUE:                           state_d = ST_COMPUTE;
            ST_COMPUTE: if (core_done)          state_d = ST_SEND;
            ST_SEND:    if (adv && seq_last)    state_d = ST_LOAD;
            default:                            state_d = ST_LOAD;
        endcase
    end

    // Outputs
    always_comb begin
        s_ready    = 1'b0;
        m_valid    = 1'b0;
        core_start = 1'b0;
        unique case (state_q)
            ST_LOAD:    s_ready    = 1'b1;
            ST_ISSUE:   core_start = 1'b1;
            ST_COMPUTE: ;
            ST_SEND:    m_valid    = 1'b1;
            default:    ;
        endcase
        m_last = m_valid && seq_last;
    end
endmodule

// File: rtl/mvw_checker.sv
module mvw_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         s_ready,
    input logic [W-1:0] m_data,
    input logic         m_valid,
    input logic         m_last,
    input logic         m_ready,
    input logic         core_start
);
    a_r2_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_ready && m_valid));

    a_r4_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> !core_start);

    a_r4_no_start_in_load: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |-> !s_ready);

    a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));

    a_r8_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        m_last |-> m_valid);

    a_r10_back_to_load: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_ready && m_last) |=> (s_ready && !m_valid));
endmodule

bind mv_stream_wrapper mvw_checker #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .s_ready    (s_ready),
    .m_data     (m_data),
    .m_valid    (m_valid),
    .m_last     (m_last),
    .m_ready    (m_ready),
    .core_start (core_start)
);

// File: tb/mv_stream_wrapper_tb.sv
module mv_stream_wrapper_tb;
    localparam int N     = 3;
    localparam int W     = 32;
    localparam int TOTAL = N * N + N;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [W-1:0]     s_data = '0;
    logic             s_valid = 1'b0;
    logic             s_last = 1'b0;
    logic             s_ready;
    logic [W-1:0]     m_data;
    logic             m_valid;
    logic             m_last;
    logic             m_ready = 1'b0;
    logic [N*N*W-1:0] core_mat;
    logic [N*W-1:0]   core_vec;
    logic             core_start;
    logic             core_done;
    logic [N*W-1:0]   core_res;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #2 clk = ~clk;

    mv_stream_wrapper #(.N(N), .W(W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
        .m_data(m_data), .m_valid(m_valid), .m_last(m_last), .m_ready(m_ready),
        .core_mat(core_mat), .core_vec(core_vec), .core_start(core_start),
        .core_done(core_done), .core_res(core_res)
    );

    // Core stand-in: integer dot products, result valid only on the done cycle.
    int          lat = 1;
    int          cnt = 0;
    logic        mdl_done = 1'b0;
    logic        spur_done = 1'b0;
    logic [N*W-1:0] good = '0;

    function automatic logic [N*W-1:0] dot(input logic [N*N*W-1:0] mt, input logic [N*W-1:0] vc);
        logic [N*W-1:0] r;
        for (int i = 0; i < N; i++) begin
            logic [W-1:0] acc;
            acc = '0;
            for (int j = 0; j < N; j++) acc = acc + mt[(i*N+j)*W +: W] * vc[j*W +: W];
            r[i*W +: W] = acc;
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            cnt <= 0;
            mdl_done <= 1'b0;
        end else begin
            mdl_done <= 1'b0;
            if (core_start) begin
                cnt  <= lat;
                good <= dot(core_mat, core_vec);
            end else if (cnt != 0) begin
                cnt <= cnt - 1;
                if (cnt == 1) mdl_done <= 1'b1;
            end
        end
    end

    assign core_done = mdl_done | spur_done;
    assign core_res  = mdl_done ? good : ~good;

    logic [W-1:0]     mat [N*N];
    logic [W-1:0]     vec [N];
    logic [W-1:0]     expres [N];
    logic [N*N*W-1:0] exp_mat;
    logic [N*W-1:0]   exp_vec;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
        end
    endtask

    task automatic make_frame(input int f);
        for (int k = 0; k < N * N; k++) begin
            mat[k] = W'(f * 1000 + k * 7 + 3);
            exp_mat[k*W +: W] = mat[k];
        end
        for (int j = 0; j < N; j++) begin
            vec[j] = W'(f * 13 + j * 5 + 1);
            exp_vec[j*W +: W] = vec[j];
        end
        for (int i = 0; i < N; i++) begin
            logic [W-1:0] acc;
            acc = '0;
            for (int j = 0; j < N; j++) acc = acc + mat[i*N+j] * vec[j];
            expres[i] = acc;
        end
    endtask

    task automatic send_frame(input int f);
        bit all_rdy;
        all_rdy = 1;
        for (int k = 0; k < TOTAL; k++) begin
            if (f % 2 == 1 && k % 3 == 1) begin
                @(negedge clk);
                s_valid = 1'b0;
            end
            @(negedge clk);
            if (f == 2 && k == 3) chk(!m_valid && s_ready, "R5 spurious done in LOAD", {m_valid, s_ready}, 2'b01);
            spur_done = (f == 2 && k == 2);
            s_valid = 1'b1;
            s_data  = (k < N * N) ? mat[k] : vec[k - N * N];
            s_last  = (k == f);   // stray marker, R9
            if (!s_ready) all_rdy = 0;
            @(posedge clk);
        end
        @(negedge clk);
        s_valid = 1'b0;
        s_last  = 1'b0;
        spur_done = 1'b0;
        chk(all_rdy, "R9 ready on every load beat despite s_last", 64'(all_rdy), 1);
        chk(!s_ready, "R2 ready low after final word", 64'(s_ready), 0);
        chk(core_start, "R4 start after final word", 64'(core_start), 1);
        chk(core_mat == exp_mat && core_vec == exp_vec, "R3 word placement",
            {core_mat[63:0]}, {exp_mat[63:0]});
        @(negedge clk);
        chk(!core_start, "R4 start one cycle", 64'(core_start), 0);
    endtask

    task automatic recv_frame(input int f);
        int i = 0;
        int cyc = 0;
        bit stalled = 0;
        logic [W-1:0] held = '0;
        logic held_last = 1'b0;
        while (i < N) begin
            @(negedge clk);
            m_ready = (f == 0) ? 1'b1 : ((cyc + f) % 3 != 0);
            cyc++;
            if (stalled)
                chk(m_valid && m_data == held && m_last == held_last, "R7 hold on stall", m_data, held);
            stalled = 0;
            if (m_valid) begin
                if (m_ready) begin
                    chk(m_data == expres[i], "R6 result order", m_data, expres[i]);
                    chk(m_last == (i == N - 1), "R8 last marker", 64'(m_last), 64'(i == N - 1));
                    i++;
                end else begin
                    stalled = 1;
                    held = m_data;
                    held_last = m_last;
                end
            end
        end
        @(negedge clk);
        m_ready = 1'b0;
        chk(s_ready && !m_valid, "R10 back to LOAD", {s_ready, m_valid}, 2'b10);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(s_ready && !m_valid && !core_start, "R1 reset state",
            {s_ready, m_valid, core_start}, 3'b100);
        rst_n = 1'b1;
        // Partial load, then reset mid-frame (R1)
        make_frame(9);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            s_valid = 1'b1;
            s_data  = mat[k];
        end
        @(negedge clk);
        s_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(s_ready && !m_valid, "R1 mid-load reset", {s_ready, m_valid}, 2'b10);
        for (int f = 0; f < 6; f++) begin
            lat = 1 + f % 4;
            make_frame(f);
            send_frame(f);
            recv_frame(f);
        end
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule